// File: doc/BRIEF.md
# Snooping MESI Line Controller

This block keeps one cache line coherent with its peers on a snooping bus using the four states Modified, Exclusive, Shared and Invalid. Several addresses map onto the one line, so a stored tag is compared against each processor request to decide hit or miss. A miss on a dirty line first writes the victim back, then fetches the new line.

The processor side accepts loads and stores held on a request until a one-cycle done pulse. The bus side raises a request with an operation and tag and holds it until the bus acknowledges. A read fill samples a wired-OR shared input at that acknowledge, and this chooses Shared or Exclusive. The snoop side takes a bus read or read-for-ownership from another cache. In the same cycle it answers with the shared drive and, when the line is dirty, with the line data and a request to cancel the memory response.

Bus arbitration and the memory array lie outside the block. The bus never acknowledges in the same cycle as a snoop.

Top module: `mesi_line_ctrl`

## Requirements
- R1: After reset the line is Invalid. A first load issues a bus read, and a snoop gets neither the shared drive nor a data supply.
- R2: A load miss issues a bus read (bus_op 0) with the request tag. If bus_shared_in is low at the acknowledge, the line is filled Exclusive and the fill data is returned.
- R3: If bus_shared_in is high at the acknowledge of a load fill, the line is filled Shared, so a later store to it issues an upgrade.
- R4: A store hit on an Exclusive or Modified line raises cpu_done in the cycle after acceptance, issues no bus request and leaves the line Modified.
- R5: A store hit on a Shared line issues a read-for-ownership (bus_op 1) with its tag and ends Modified with the store data.
- R6: A store miss issues a read-for-ownership and fills the line Modified, holding the store data rather than the bus data.
- R7: A snooped read (snp_op 0) that matches a valid line drives snp_shared_out. From Modified it also supplies the line data on snp_data with snp_supply high. From Modified or Exclusive the line then moves to Shared.
- R8: A snooped read-for-ownership (snp_op 1) that matches a valid line invalidates it. Only a Modified line supplies data, and no shared drive is given.
- R9: A snoop whose tag does not match, or that finds the line Invalid, drives neither output and leaves the line unchanged.
- R10: A miss that replaces a Modified line first issues a write-back (bus_op 2) carrying the old tag and data, then the fill. A clean victim is dropped with no write-back.
- R11: A load hit returns the line data with cpu_done in the cycle after acceptance and issues no bus request.
- R12: A processor request is not accepted in a cycle with snp_valid high, so the snoop's effect on the line is seen first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_req | input | 1 | Processor request, held until cpu_done |
| cpu_we | input | 1 | 1 = store, 0 = load |
| cpu_tag | input | TAG_W | Request address tag |
| cpu_wdata | input | DATA_W | Store data |
| cpu_done | output | 1 | One-cycle completion pulse |
| cpu_rdata | output | DATA_W | Load data, valid with cpu_done |
| bus_req | output | 1 | Bus request, held until bus_ack |
| bus_op | output | 2 | 0 read, 1 read-for-ownership, 2 write-back |
| bus_tag | output | TAG_W | Tag of the bus transaction |
| bus_wdata | output | DATA_W | Write-back data |
| bus_ack | input | 1 | Bus completion, one cycle |
| bus_rdata | input | DATA_W | Fill data at bus_ack |
| bus_shared_in | input | 1 | Wired-OR shared signal from other caches, sampled at bus_ack |
| snp_valid | input | 1 | Snooped transaction present |
| snp_op | input | 1 | 0 read, 1 read-for-ownership |
| snp_tag | input | TAG_W | Snooped tag |
| snp_shared_out | output | 1 | Drive onto the shared line |
| snp_supply | output | 1 | Line data supplied, memory response cancelled |
| snp_data | output | DATA_W | Supplied line data |

## Verification
On every cycle the assertions check these rules: snoop outputs stay quiet without a snoop, and a data supply comes only from a dirty line. A supplying snooped read also drives the shared line. Snooped reads and read-for-ownership leave the line Shared and Invalid respectively. Bus requests hold steady until acknowledged, a write-back is always followed by a fill, and the done pulse lasts one cycle. Only the bench's scenarios show which state a fill lands in, because that is visible only through the next store's bus traffic. The same holds for silent store upgrades, the data carried by write-backs and flushes, and snoop priority over a simultaneous processor request.

// File: rtl/mesi_pkg.sv
package mesi_pkg;
  typedef enum logic [1:0] {ST_I = 2'd0, ST_S = 2'd1, ST_E = 2'd2, ST_M = 2'd3} line_st_t;
  typedef enum logic [1:0] {OP_RD = 2'd0, OP_RDX = 2'd1, OP_WB = 2'd2} bus_op_t;
  typedef enum logic [1:0] {F_IDLE = 2'd0, F_WB = 2'd1, F_FILL = 2'd2} fsm_t;

  // State a fill lands in: stores own the line, loads depend on the shared line.
  function automatic line_st_t fill_state(input logic is_store, input logic shared);
    if (is_store)    return ST_M;
    else if (shared) return ST_S;
    else             return ST_E;
  endfunction

  // State after a snoop that matched (active) a valid line.
  function automatic line_st_t snoop_next(input line_st_t st, input logic active, input logic rdx);
    if (!active)  return st;
    else if (rdx) return ST_I;
    else          return ST_S;
  endfunction
endpackage

// File: rtl/mesi_tag_match.sv
module mesi_tag_match #(
  parameter int TAG_W = 4
) (
  input  logic             valid,
  input  logic [TAG_W-1:0] line_tag,
  input  logic [TAG_W-1:0] req_tag,
  output logic             hit
);
  assign hit = valid && (line_tag == req_tag);
endmodule

// File: rtl/mesi_snoop_resp.sv
module mesi_snoop_resp
  import mesi_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              snp_valid,
  input  logic              snp_rdx,
  input  logic              snp_hit,
  input  line_st_t          st,
  input  logic [DATA_W-1:0] line_data,
  output logic              shared_out,
  output logic              supply,
  output logic [DATA_W-1:0] supply_data,
  output line_st_t          st_next
);
  logic active;
  assign active      = snp_valid && snp_hit;
  assign shared_out  = active && !snp_rdx;
  assign supply      = active && (st == ST_M);
  assign supply_data = supply ? line_data : '0;
  assign st_next     = snoop_next(st, active, snp_rdx);
endmodule

// File: rtl/mesi_line_ctrl.sv
module mesi_line_ctrl
  import mesi_pkg::*;
#(
  parameter int TAG_W  = 4,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_req,
  input  logic              cpu_we,
  input  logic [TAG_W-1:0]  cpu_tag,
  input  logic [DATA_W-1:0] cpu_wdata,
  output logic              cpu_done,
  output logic [DATA_W-1:0] cpu_rdata,
  output logic              bus_req,
  output logic [1:0]        bus_op,
  output logic [TAG_W-1:0]  bus_tag,
  output logic [DATA_W-1:0] bus_wdata,
  input  logic              bus_ack,
  input  logic [DATA_W-1:0] bus_rdata,
  input  logic              bus_shared_in,
  input  logic              snp_valid,
  input  logic              snp_op,
  input  logic [TAG_W-1:0]  snp_tag,
  output logic              snp_shared_out,
  output logic              snp_supply,
  output logic [DATA_W-1:0] snp_data
);
  line_st_t          st;
  line_st_t          snp_st_next;
  fsm_t              fsm;
  logic [TAG_W-1:0]  line_tag, pend_tag;
  logic [DATA_W-1:0] line_data, pend_wdata;
  logic              pend_we;
  logic              line_valid, cpu_hit, snp_hit, accept;

  // Named internal events for the checker
  assign line_valid = (st != ST_I);
  assign accept     = (fsm == F_IDLE) && cpu_req && !cpu_done && !snp_valid;

  mesi_tag_match #(.TAG_W(TAG_W)) u_cpu_cmp (
    .valid(line_valid), .line_tag(line_tag), .req_tag(cpu_tag), .hit(cpu_hit));

  mesi_tag_match #(.TAG_W(TAG_W)) u_snp_cmp (
    .valid(line_valid), .line_tag(line_tag), .req_tag(snp_tag), .hit(snp_hit));

  mesi_snoop_resp #(.DATA_W(DATA_W)) u_snoop (
    .snp_valid(snp_valid), .snp_rdx(snp_op), .snp_hit(snp_hit), .st(st),
    .line_data(line_data), .shared_out(snp_shared_out), .supply(snp_supply),
    .supply_data(snp_data), .st_next(snp_st_next));

  // Bus side is a decode of the sequencer state
  assign bus_req   = (fsm != F_IDLE);
  assign bus_op    = (fsm == F_WB) ? OP_WB : (pend_we ? OP_RDX : OP_RD);
  assign bus_tag   = (fsm == F_WB) ? line_tag : pend_tag;
  assign bus_wdata = line_data;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st         <= ST_I;
      fsm        <= F_IDLE;
      line_tag   <= '0;
      line_data  <= '0;
      pend_tag   <= '0;
      pend_wdata <= '0;
      pend_we    <= 1'b0;
      cpu_done   <= 1'b0;
      cpu_rdata  <= '0;
    end else begin
      cpu_done <= 1'b0;
      if (snp_valid) st <= snp_st_next;
      unique case (fsm)
        F_IDLE: begin
          if (accept) begin
            pend_tag   <= cpu_tag;
            pend_we    <= cpu_we;
            pend_wdata <= cpu_wdata;
            if (cpu_hit) begin
              if (!cpu_we) begin
                cpu_done  <= 1'b1;
                cpu_rdata <= line_data;
              end else if (st == ST_S) begin
                fsm <= F_FILL;
              end else begin
                st        <= ST_M;
                line_data <= cpu_wdata;
                cpu_done  <= 1'b1;
              end
            end else if (st == ST_M) begin
              fsm <= F_WB;
            end else begin
              fsm <= F_FILL;
            end
          end
        end
        F_WB: begin
          if (bus_ack) begin
            st  <= ST_I;
            fsm <= F_FILL;
          end
        end
        F_FILL: begin
          if (bus_ack) begin
            line_tag  <= pend_tag;
            st        <= fill_state(pend_we, bus_shared_in);
            line_data <= pend_we ? pend_wdata : bus_rdata;
            cpu_rdata <= bus_rdata;
            cpu_done  <= 1'b1;
            fsm       <= F_IDLE;
          end
        end
        default: fsm <= F_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/mesi_line_chk.sv
module mesi_line_chk #(
  parameter int TAG_W = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cpu_done,
  input logic             bus_req,
  input logic [1:0]       bus_op,
  input logic [TAG_W-1:0] bus_tag,
  input logic             bus_ack,
  input logic             snp_valid,
  input logic             snp_op,
  input logic             snp_shared_out,
  input logic             snp_supply,
  input logic [1:0]       st
);
  AST_SUPPLY_ONLY_DIRTY: assert property (@(posedge clk) disable iff (!rst_n)
    snp_supply |-> st == 2'd3); // R8
  AST_QUIET_WITHOUT_SNOOP: assert property (@(posedge clk) disable iff (!rst_n)
    !snp_valid |-> (!snp_shared_out && !snp_supply)); // R9
  AST_RD_SUPPLY_SHARES: assert property (@(posedge clk) disable iff (!rst_n)
    (snp_valid && !snp_op && snp_supply) |-> snp_shared_out); // R7
  AST_RD_SNOOP_DEMOTES: assert property (@(posedge clk) disable iff (!rst_n)
    (snp_valid && !snp_op && snp_shared_out && !bus_ack) |=> st == 2'd1); // R7
  AST_RDX_SNOOP_INVALIDATES: assert property (@(posedge clk) disable iff (!rst_n)
    (snp_valid && snp_op && snp_supply && !bus_ack) |=> st == 2'd0); // R8
  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_done |=> !cpu_done); // R11
  AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && !bus_ack) |=> (bus_req && $stable(bus_op) && $stable(bus_tag))); // R10
  AST_WB_THEN_FILL: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && bus_op == 2'd2 && bus_ack) |=> (bus_req && bus_op != 2'd2)); // R10
  AST_OP_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req |-> bus_op != 2'd3); // R5
endmodule

bind mesi_line_ctrl mesi_line_chk #(.TAG_W(TAG_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cpu_done(cpu_done), .bus_req(bus_req),
  .bus_op(bus_op), .bus_tag(bus_tag), .bus_ack(bus_ack), .snp_valid(snp_valid),
  .snp_op(snp_op), .snp_shared_out(snp_shared_out), .snp_supply(snp_supply),
  .st(st));

// File: tb/mesi_line_ctrl_test.sv
module mesi_line_ctrl_test;
  logic        clk = 1'b0, rst_n = 1'b0;
  logic        cpu_req = 0, cpu_we = 0, cpu_done;
  logic [3:0]  cpu_tag = 0;
  logic [15:0] cpu_wdata = 0, cpu_rdata;
  logic        bus_req, bus_ack = 0, bus_shared_in = 0;
  logic [1:0]  bus_op;
  logic [3:0]  bus_tag;
  logic [15:0] bus_wdata, bus_rdata = 0;
  logic        snp_valid = 0, snp_op = 0, snp_shared_out, snp_supply;
  logic [3:0]  snp_tag = 0;
  logic [15:0] snp_data;
  int errors = 0, checks = 0;

  always #10 clk = ~clk; // 50 MHz

  mesi_line_ctrl uut (.*);

  // Scoreboard queues: {op, tag, wdata, rdata, shared}
  logic [38:0] bq[$];
  string       br[$];
  logic [16:0] cq[$]; // {check_data, rdata}
  string       cr[$];

  task automatic chk(input logic ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic exp_bus(input logic [1:0] op, input logic [3:0] tag, input logic [15:0] wd,
                         input logic [15:0] rd, input logic sh, input string req);
    bq.push_back({op, tag, wd, rd, sh});
    br.push_back(req);
  endtask

  // Monitor / bus responder
  always @(negedge clk) begin
    if (bus_ack) begin
      bus_ack = 1'b0;
    end else if (bus_req && rst_n) begin
      if (bq.size() == 0) begin
        chk(1'b0, "R4/R11", "unexpected bus op", {30'd0, bus_op}, 32'hFF);
        bus_rdata = 16'h0; bus_shared_in = 1'b0;
      end else begin
        logic [38:0] it;
        string r;
        it = bq.pop_front();
        r  = br.pop_front();
        chk(bus_op == it[38:37], r, "bus_op", {30'd0, bus_op}, {30'd0, it[38:37]});
        chk(bus_tag == it[36:33], r, "bus_tag", {28'd0, bus_tag}, {28'd0, it[36:33]});
        if (it[38:37] == 2'd2)
          chk(bus_wdata == it[32:17], r, "bus_wdata", {16'd0, bus_wdata}, {16'd0, it[32:17]});
        bus_rdata     = it[16:1];
        bus_shared_in = it[0];
      end
      bus_ack = 1'b1;
    end
    if (cpu_done) begin
      if (cq.size() == 0) begin
        chk(1'b0, "R11", "unexpected done", 32'd1, 32'd0);
      end else begin
        logic [16:0] c;
        string r;
        c = cq.pop_front();
        r = cr.pop_front();
        if (c[16]) chk(cpu_rdata == c[15:0], r, "cpu_rdata", {16'd0, cpu_rdata}, {16'd0, c[15:0]});
      end
    end
  end

  task automatic cpu_op(input logic we, input logic [3:0] tag, input logic [15:0] wd,
                        input logic [15:0] exp_rd, input string req);
    cq.push_back({!we, exp_rd});
    cr.push_back(req);
    @(negedge clk);
    cpu_req = 1'b1; cpu_we = we; cpu_tag = tag; cpu_wdata = wd;
    do @(negedge clk); while (!cpu_done);
    cpu_req = 1'b0;
    chk(bq.size() == 0, req, "expected bus ops left", bq.size(), 0);
  endtask

  task automatic snoop(input logic rdx, input logic [3:0] tag, input logic exp_sh,
                       input logic exp_sup, input logic [15:0] exp_d, input string req);
    @(negedge clk);
    snp_valid = 1'b1; snp_op = rdx; snp_tag = tag;
    #1;
    chk(snp_shared_out == exp_sh, req, "snp_shared_out", {31'd0, snp_shared_out}, {31'd0, exp_sh});
    chk(snp_supply == exp_sup, req, "snp_supply", {31'd0, snp_supply}, {31'd0, exp_sup});
    if (exp_sup) chk(snp_data == exp_d, req, "snp_data", {16'd0, snp_data}, {16'd0, exp_d});
    @(negedge clk);
    snp_valid = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    chk(1'b0, "ALL", "watchdog expired", 0, 1);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!cpu_done && !bus_req, "R1", "idle after reset", {30'd0, cpu_done, bus_req}, 0);
    snoop(1'b0, 4'h3, 1'b0, 1'b0, 16'h0, "R1");
    // R2: exclusive fill, then silent store (R4)
    exp_bus(2'd0, 4'h3, 16'h0, 16'h00A1, 1'b0, "R2");
    cpu_op(1'b0, 4'h3, 16'h0, 16'h00A1, "R2");
    cpu_op(1'b1, 4'h3, 16'h00B1, 16'h0, "R4");
    snoop(1'b0, 4'h3, 1'b1, 1'b1, 16'h00B1, "R7");          // M -> S with flush
    cpu_op(1'b0, 4'h3, 16'h0, 16'h00B1, "R11");             // load hit, no bus
    exp_bus(2'd1, 4'h3, 16'h0, 16'h00B1, 1'b0, "R5");
    cpu_op(1'b1, 4'h3, 16'h00C1, 16'h0, "R5");              // upgrade from S
    cpu_op(1'b1, 4'h3, 16'h00C2, 16'h0, "R4");              // M store hit silent
    snoop(1'b1, 4'h3, 1'b0, 1'b1, 16'h00C2, "R8");          // M flush + invalidate
    snoop(1'b0, 4'h3, 1'b0, 1'b0, 16'h0, "R9");             // now invalid
    // R3: shared fill
    exp_bus(2'd0, 4'h5, 16'h0, 16'h00D5, 1'b1, "R3");
    cpu_op(1'b0, 4'h5, 16'h0, 16'h00D5, "R3");
    snoop(1'b0, 4'h6, 1'b0, 1'b0, 16'h0, "R9");             // tag mismatch
    exp_bus(2'd1, 4'h5, 16'h0, 16'h00D5, 1'b0, "R3");
    cpu_op(1'b1, 4'h5, 16'h00E5, 16'h0, "R3");              // S store upgrades
    // R10: dirty victim write-back then fill
    exp_bus(2'd2, 4'h5, 16'h00E5, 16'h0, 1'b0, "R10");
    exp_bus(2'd0, 4'h7, 16'h0, 16'h00F7, 1'b0, "R10");
    cpu_op(1'b0, 4'h7, 16'h0, 16'h00F7, "R10");
    snoop(1'b0, 4'h7, 1'b1, 1'b0, 16'h0, "R7");             // E -> S, no supply
    exp_bus(2'd1, 4'h7, 16'h0, 16'h00F7, 1'b0, "R7");
    cpu_op(1'b1, 4'h7, 16'h0077, 16'h0, "R7");              // proves it was S
    snoop(1'b1, 4'h7, 1'b0, 1'b1, 16'h0077, "R8");
    // R8: exclusive line invalidated without supply
    exp_bus(2'd0, 4'h2, 16'h0, 16'h0022, 1'b0, "R8");
    cpu_op(1'b0, 4'h2, 16'h0, 16'h0022, "R8");
    snoop(1'b1, 4'h2, 1'b0, 1'b0, 16'h0, "R8");
    exp_bus(2'd0, 4'h2, 16'h0, 16'h0023, 1'b0, "R8");
    cpu_op(1'b0, 4'h2, 16'h0, 16'h0023, "R8");              // miss proves invalid
    // R6 + clean victim (R10): store miss over E line, no write-back
    exp_bus(2'd1, 4'h9, 16'h0, 16'h1111, 1'b0, "R6");
    cpu_op(1'b1, 4'h9, 16'h0099, 16'h0, "R10");
    snoop(1'b0, 4'h9, 1'b1, 1'b1, 16'h0099, "R6");          // holds store data
    // R12: snoop invalidate in the same cycle as a load request
    exp_bus(2'd0, 4'h9, 16'h0, 16'h005A, 1'b0, "R12");
    cq.push_back({1'b1, 16'h005A});
    cr.push_back("R12");
    @(negedge clk);
    cpu_req = 1'b1; cpu_we = 1'b0; cpu_tag = 4'h9;
    snp_valid = 1'b1; snp_op = 1'b1; snp_tag = 4'h9;
    @(negedge clk);
    snp_valid = 1'b0;
    while (!cpu_done) @(negedge clk);
    cpu_req = 1'b0;
    chk(bq.size() == 0, "R12", "expected bus ops left", bq.size(), 0);
    repeat (3) @(negedge clk);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule